// File: doc/BRIEF.md
# Audio bit and frame clock generator

This block produces the serial bit clock and the left/right frame clock for one audio port. It runs on the master audio clock, and the bit clock is derived from two encoded ratios: the number of master clocks in one frame and the number of bit clocks in one frame. The divisor is the first ratio divided by the second. The frame clock is low for the first half of the bits in a frame and high for the second half. Along with the clocks it produces one-cycle strobes for a serial shifter: one at the start of each bit and one at the start of each frame. The shifter itself is not part of the block.

Each data direction (transmit and receive) is either master, so that it takes its strobes from the internal generator, or slave, so that its strobes come from externally supplied clocks after resynchronisation. The generated clocks are driven whenever at least one direction is master. Separate inversion bits apply to the bit and frame clocks in master mode and in slave mode. A port enable starts the generator and latches the ratios. Clearing the enable lets the current frame finish, and then the clocks return to their idle level.

The generator is a four-state machine. IDLE holds the counters at zero. IDLE goes to RUN when the port is enabled, a direction is master and the ratios are legal, and it goes to FAULT when the ratios are illegal. RUN goes to STOP when the enable drops before a frame boundary, and it goes back to IDLE when the enable is low at a frame boundary. STOP goes back to RUN when the enable returns, and it goes to IDLE at the frame boundary. FAULT goes to IDLE once the enable or both master bits drop.

Top module: `aclk_gen`

## Requirements
- R1: The frame-ratio code in clk_div_cfg[14:12] selects 512, 256, 128, 64 or 32 master clocks per frame for codes 0 to 4. Codes 5 to 7 are illegal. A running master port emits one frame strobe every frame-ratio master clocks.
- R2: The bits-per-frame code in clk_div_cfg[10:8] selects 32, 64, 128, 256 or 512 for codes 0 to 4 and 16 for code 7. Codes 5 and 6 are illegal.
- R3: If either code is illegal, or the frame ratio divided by bits per frame is below 2, enabling the port raises cfg_err. cfg_err stays high until the port is disabled. While it is high the clocks stay at their idle level and no master strobe is produced.
- R4: In master mode the raw bit clock is low for the first half of each bit period and high for the second half. Its period is the frame ratio divided by bits per frame, in master clocks.
- R5: The raw frame clock is low during the first half of the bits of a frame and high during the second half.
- R6: A master bit strobe lasts one cycle, in the first master clock of each bit. A frame strobe coincides with the bit strobe of bit 0. The first frame begins in the cycle after the start is accepted.
- R7: The generator starts only when port_en is high and clk_div_cfg[0] or clk_div_cfg[4] is set. The ratios are captured at the start, and changes made to them while the port is running have no effect.
- R8: When port_en drops, the current frame completes. After the last cycle of that frame the raw clocks go low. If port_en returns before that boundary, the port keeps running without a break.
- R9: clk_pol_cfg[12] inverts the generated frame clock and clk_pol_cfg[8] inverts the generated bit clock. This applies also at their idle level.
- R10: For a slave direction, the external bit clock and frame clock pass through a two-stage synchroniser. A bit strobe fires on each falling edge of the corrected bit clock, two cycles after the pin changes. A frame strobe fires on such an edge when the corrected frame clock is low and was high at the previous edge. Slave strobes are suppressed while port_en is low.
- R11: clk_pol_cfg[4] inverts the external frame clock and clk_pol_cfg[0] inverts the external bit clock before edge detection.
- R12: clk_div_cfg[0] makes the transmit strobes come from the generator and clk_div_cfg[4] does the same for the receive strobes. When a bit is clear, that direction uses the slave strobes. clk_oe is high when either bit is set.
- R13: After reset the generator is in IDLE. The raw clocks are low, all strobes are low and cfg_err is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master audio clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| port_en | input | 1 | Port clock enable |
| clk_div_cfg | input | 16 | Ratio codes and per-direction master bits |
| clk_pol_cfg | input | 16 | Clock inversion bits for master and slave mode |
| ext_bclk_i | input | 1 | External bit clock (slave) |
| ext_fclk_i | input | 1 | External frame clock (slave) |
| bclk_o | output | 1 | Generated bit clock after inversion |
| fclk_o | output | 1 | Generated frame clock after inversion |
| clk_oe | output | 1 | Drive enable for the generated clocks |
| tx_bit_stb | output | 1 | Transmit bit-start strobe |
| tx_frame_stb | output | 1 | Transmit frame-start strobe |
| rx_bit_stb | output | 1 | Receive bit-start strobe |
| rx_frame_stb | output | 1 | Receive frame-start strobe |
| cfg_err | output | 1 | Illegal ratio setting seen at enable |

## Verification
The properties make no assumption about the ratio codes. The single-cycle frame-strobe property, however, only judges cycles in which the configuration word has not changed, because switching a direction between master and slave legitimately hands the strobe to a different source. The slave path relies on each external clock level lasting at least two master clocks, since a shorter level could slip through the synchroniser. The stimulus therefore drives external half periods of three or more cycles, changes the pin level and its inversion bit together only while the port is disabled, and changes the ratios during a run only in the test that shows they are ignored.

// File: rtl/aclk_pkg.sv
package aclk_pkg;

    localparam int CODE_W       = 3;
    localparam int LOG_W        = 4;
    localparam int FRM_LOG_TOP  = 9;
    localparam int FRM_CODE_MAX = 4;
    localparam int BPF_LOG_BASE = 5;
    localparam int BPF_CODE_MAX = 4;
    localparam int BPF_CODE_16  = 7;
    localparam int BPF_LOG_16   = 4;
    localparam int MAX_DIV_LOG  = FRM_LOG_TOP - BPF_LOG_16;
    localparam int MAX_BPF_LOG  = BPF_LOG_BASE + BPF_CODE_MAX;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_STOP  = 2'd2,
        ST_FAULT = 2'd3
    } gen_state_e;

    typedef struct packed {
        logic bit_stb;
        logic frame_stb;
    } stb_pair_t;

endpackage

// File: rtl/aclk_ratio_dec.sv
module aclk_ratio_dec
    import aclk_pkg::*;
#(
    parameter int CW = CODE_W,
    parameter int LW = LOG_W
) (
    input  logic [CW-1:0] frm_code,
    input  logic [CW-1:0] bpf_code,
    output logic          ratio_ok,
    output logic [LW-1:0] div_log,
    output logic [LW-1:0] bpf_log
);

    logic          frm_ok;
    logic          bpf_ok;
    logic [LW-1:0] frm_log;

    always_comb begin
        frm_ok  = (int'(frm_code) <= FRM_CODE_MAX);
        frm_log = LW'(FRM_LOG_TOP) - LW'(frm_code);
    end

    always_comb begin
        if (int'(bpf_code) <= BPF_CODE_MAX) begin
            bpf_ok  = 1'b1;
            bpf_log = LW'(BPF_LOG_BASE) + LW'(bpf_code);
        end else if (int'(bpf_code) == BPF_CODE_16) begin
            bpf_ok  = 1'b1;
            bpf_log = LW'(BPF_LOG_16);
        end else begin
            bpf_ok  = 1'b0;
            bpf_log = LW'(BPF_LOG_BASE);
        end
    end

    always_comb begin
        ratio_ok = frm_ok && bpf_ok && (frm_log > bpf_log);
        div_log  = ratio_ok ? (frm_log - bpf_log) : LW'(1);
    end

endmodule

// File: rtl/aclk_master_fsm.sv
module aclk_master_fsm
    import aclk_pkg::*;
#(
    parameter int LW    = LOG_W,
    parameter int CYC_W = MAX_DIV_LOG,
    parameter int BIT_W = MAX_BPF_LOG
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go,
    input  logic          ratio_ok,
    input  logic [LW-1:0] div_log_in,
    input  logic [LW-1:0] bpf_log_in,
    output logic          bclk_raw,
    output logic          fclk_raw,
    output stb_pair_t     stb,
    output logic          fault
);

    localparam int CYC_XW = CYC_W + 1;
    localparam int BIT_XW = BIT_W + 1;

    gen_state_e        state_q;
    gen_state_e        state_d;
    logic [CYC_W-1:0]  cyc_q;
    logic [BIT_W-1:0]  bit_q;
    logic [LW-1:0]     div_log_q;
    logic [LW-1:0]     bpf_log_q;

    logic [CYC_XW-1:0] cyc_lim;
    logic [BIT_XW-1:0] bit_lim;
    logic              cyc_end;
    logic              bit_end;
    logic              frame_end;
    logic              running;

    always_comb begin
        cyc_lim   = CYC_XW'(1) << div_log_q;
        bit_lim   = BIT_XW'(1) << bpf_log_q;
        cyc_end   = ({1'b0, cyc_q} == (cyc_lim - CYC_XW'(1)));
        bit_end   = ({1'b0, bit_q} == (bit_lim - BIT_XW'(1)));
        frame_end = cyc_end && bit_end;
        running   = (state_q == ST_RUN) || (state_q == ST_STOP);
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (go) begin
                    state_d = ratio_ok ? ST_RUN : ST_FAULT;
                end
            end
            ST_RUN: begin
                if (!go) begin
                    state_d = frame_end ? ST_IDLE : ST_STOP;
                end
            end
            ST_STOP: begin
                if (go) begin
                    state_d = ST_RUN;
                end else if (frame_end) begin
                    state_d = ST_IDLE;
                end
            end
            ST_FAULT: begin
                if (!go) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cyc_q     <= '0;
            bit_q     <= '0;
            div_log_q <= LW'(1);
            bpf_log_q <= LW'(BPF_LOG_BASE);
        end else if (state_q == ST_IDLE) begin
            cyc_q <= '0;
            bit_q <= '0;
            if (go && ratio_ok) begin
                div_log_q <= div_log_in;
                bpf_log_q <= bpf_log_in;
            end
        end else if (running) begin
            if (cyc_end) begin
                cyc_q <= '0;
                bit_q <= bit_end ? '0 : bit_q + BIT_W'(1);
            end else begin
                cyc_q <= cyc_q + CYC_W'(1);
            end
        end
    end

    always_comb begin
        bclk_raw      = 1'b0;
        fclk_raw      = 1'b0;
        stb.bit_stb   = 1'b0;
        stb.frame_stb = 1'b0;
        fault         = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
            end
            ST_RUN, ST_STOP: begin
                bclk_raw      = ({1'b0, cyc_q} >= (cyc_lim >> 1));
                fclk_raw      = ({1'b0, bit_q} >= (bit_lim >> 1));
                stb.bit_stb   = (cyc_q == '0);
                stb.frame_stb = (cyc_q == '0) && (bit_q == '0);
            end
            ST_FAULT: begin
                fault = 1'b1;
            end
            default: begin
            end
        endcase
    end

endmodule

// File: rtl/aclk_slave_track.sv
module aclk_slave_track
    import aclk_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      enable,
    input  logic      ext_bclk,
    input  logic      ext_fclk,
    input  logic      inv_bclk,
    input  logic      inv_fclk,
    output stb_pair_t stb
);

    localparam int BP_W = SYNC_STAGES + 1;

    logic [BP_W-1:0]        b_pipe;
    logic [SYNC_STAGES-1:0] f_pipe;
    logic                   fclk_at_edge_q;
    logic                   b_now;
    logic                   b_prev;
    logic                   f_now;
    logic                   fall;

    genvar gi;
    generate
        for (gi = 0; gi < BP_W; gi++) begin : g_bsync
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    b_pipe[gi] <= 1'b0;
                end else if (gi == 0) begin
                    b_pipe[gi] <= ext_bclk;
                end else begin
                    b_pipe[gi] <= b_pipe[(gi == 0) ? 0 : gi-1];
                end
            end
        end
        for (gi = 0; gi < SYNC_STAGES; gi++) begin : g_fsync
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    f_pipe[gi] <= 1'b0;
                end else if (gi == 0) begin
                    f_pipe[gi] <= ext_fclk;
                end else begin
                    f_pipe[gi] <= f_pipe[(gi == 0) ? 0 : gi-1];
                end
            end
        end
    endgenerate

    always_comb begin
        b_now  = b_pipe[SYNC_STAGES-1] ^ inv_bclk;
        b_prev = b_pipe[SYNC_STAGES] ^ inv_bclk;
        f_now  = f_pipe[SYNC_STAGES-1] ^ inv_fclk;
        fall   = b_prev && !b_now;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fclk_at_edge_q <= 1'b0;
        end else if (fall) begin
            fclk_at_edge_q <= f_now;
        end
    end

    always_comb begin
        stb.bit_stb   = enable && fall;
        stb.frame_stb = enable && fall && !f_now && fclk_at_edge_q;
    end

endmodule

// File: rtl/aclk_gen.sv
module aclk_gen
    import aclk_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        port_en,
    input  logic [15:0] clk_div_cfg,
    input  logic [15:0] clk_pol_cfg,
    input  logic        ext_bclk_i,
    input  logic        ext_fclk_i,
    output logic        bclk_o,
    output logic        fclk_o,
    output logic        clk_oe,
    output logic        tx_bit_stb,
    output logic        tx_frame_stb,
    output logic        rx_bit_stb,
    output logic        rx_frame_stb,
    output logic        cfg_err
);

    localparam int FRM_LSB = 12;
    localparam int BPF_LSB = 8;
    localparam int TX_MST  = 0;
    localparam int RX_MST  = 4;
    localparam int INV_FM  = 12;
    localparam int INV_BM  = 8;
    localparam int INV_FS  = 4;
    localparam int INV_BS  = 0;

    logic             go;
    logic             ratio_ok;
    logic [LOG_W-1:0] div_log;
    logic [LOG_W-1:0] bpf_log;
    logic             bclk_raw;
    logic             fclk_raw;
    stb_pair_t        mst_stb;
    stb_pair_t        slv_stb;
    logic             fault;

    assign go = port_en && (clk_div_cfg[TX_MST] || clk_div_cfg[RX_MST]);

    aclk_ratio_dec u_dec (
        .frm_code (clk_div_cfg[FRM_LSB +: CODE_W]),
        .bpf_code (clk_div_cfg[BPF_LSB +: CODE_W]),
        .ratio_ok (ratio_ok),
        .div_log  (div_log),
        .bpf_log  (bpf_log)
    );

    aclk_master_fsm u_mst (
        .clk        (clk),
        .rst_n      (rst_n),
        .go         (go),
        .ratio_ok   (ratio_ok),
        .div_log_in (div_log),
        .bpf_log_in (bpf_log),
        .bclk_raw   (bclk_raw),
        .fclk_raw   (fclk_raw),
        .stb        (mst_stb),
        .fault      (fault)
    );

    aclk_slave_track u_slv (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (port_en),
        .ext_bclk (ext_bclk_i),
        .ext_fclk (ext_fclk_i),
        .inv_bclk (clk_pol_cfg[INV_BS]),
        .inv_fclk (clk_pol_cfg[INV_FS]),
        .stb      (slv_stb)
    );

    always_comb begin
        bclk_o       = bclk_raw ^ clk_pol_cfg[INV_BM];
        fclk_o       = fclk_raw ^ clk_pol_cfg[INV_FM];
        clk_oe       = clk_div_cfg[TX_MST] || clk_div_cfg[RX_MST];
        cfg_err      = fault;
        tx_bit_stb   = clk_div_cfg[TX_MST] ? mst_stb.bit_stb   : slv_stb.bit_stb;
        tx_frame_stb = clk_div_cfg[TX_MST] ? mst_stb.frame_stb : slv_stb.frame_stb;
        rx_bit_stb   = clk_div_cfg[RX_MST] ? mst_stb.bit_stb   : slv_stb.bit_stb;
        rx_frame_stb = clk_div_cfg[RX_MST] ? mst_stb.frame_stb : slv_stb.frame_stb;
    end

endmodule

// File: rtl/aclk_gen_chk.sv
module aclk_gen_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        port_en,
    input logic [15:0] clk_div_cfg,
    input logic [15:0] clk_pol_cfg,
    input logic        bclk_o,
    input logic        fclk_o,
    input logic        tx_bit_stb,
    input logic        tx_frame_stb,
    input logic        rx_bit_stb,
    input logic        rx_frame_stb,
    input logic        cfg_err
);

    AST_ERR_CLK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> (bclk_o == clk_pol_cfg[8]) && (fclk_o == clk_pol_cfg[12])); // R3

    AST_ERR_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_err && clk_div_cfg[0]) |-> !tx_bit_stb); // R3

    AST_ERR_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cfg_err) |-> $past(port_en)); // R3

    AST_FRAME_ON_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_frame_stb |-> tx_bit_stb) and (rx_frame_stb |-> rx_bit_stb)); // R6

    AST_FRAME_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_frame_stb ##1 $stable(clk_div_cfg)) |-> !tx_frame_stb); // R6

    AST_SLAVE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (!port_en && !clk_div_cfg[4]) |-> !rx_bit_stb); // R10

endmodule

bind aclk_gen aclk_gen_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .port_en      (port_en),
    .clk_div_cfg  (clk_div_cfg),
    .clk_pol_cfg  (clk_pol_cfg),
    .bclk_o       (bclk_o),
    .fclk_o       (fclk_o),
    .tx_bit_stb   (tx_bit_stb),
    .tx_frame_stb (tx_frame_stb),
    .rx_bit_stb   (rx_bit_stb),
    .rx_frame_stb (rx_frame_stb),
    .cfg_err      (cfg_err)
);

// File: tb/aclk_gen_test.sv
module aclk_gen_test;

    localparam int CLK_PERIOD = 10;
    localparam int WDOG_CYC   = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        port_en = 1'b0;
    logic [15:0] clk_div_cfg = 16'h0;
    logic [15:0] clk_pol_cfg = 16'h0;
    logic        ext_bclk_i = 1'b0;
    logic        ext_fclk_i = 1'b0;
    logic        bclk_o, fclk_o, clk_oe;
    logic        tx_bit_stb, tx_frame_stb, rx_bit_stb, rx_frame_stb, cfg_err;

    always #(CLK_PERIOD/2) clk = ~clk;

    aclk_gen uut (
        .clk(clk), .rst_n(rst_n), .port_en(port_en),
        .clk_div_cfg(clk_div_cfg), .clk_pol_cfg(clk_pol_cfg),
        .ext_bclk_i(ext_bclk_i), .ext_fclk_i(ext_fclk_i),
        .bclk_o(bclk_o), .fclk_o(fclk_o), .clk_oe(clk_oe),
        .tx_bit_stb(tx_bit_stb), .tx_frame_stb(tx_frame_stb),
        .rx_bit_stb(rx_bit_stb), .rx_frame_stb(rx_frame_stb),
        .cfg_err(cfg_err)
    );

    // reference model state
    int ms = 0;
    int mcyc = 0, mbit = 0, mdiv = 2, mbpf = 32;
    logic hb[$];
    logic hf[$];
    logic fl_m = 1'b0;
    int mdl_checks = 0, mdl_fails = 0;
    int exp_checks = 0, exp_fails = 0;
    int frm_len = 0, last_len = 0;
    int slv_bits = 0, slv_frames = 0;

    function automatic int frm_of(input logic [2:0] c);
        return (c <= 3'd4) ? (512 >> c) : 0;
    endfunction

    function automatic int bpf_of(input logic [2:0] c);
        if (c <= 3'd4) return 32 << c;
        if (c == 3'd7) return 16;
        return 0;
    endfunction

    task automatic cmp(input string tag, input string what, input logic act, input logic exp);
        mdl_checks++;
        if (act !== exp) begin
            mdl_fails++;
            $display("FAIL %s %s actual=%b expected=%b at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic chk(input string tag, input string what, input int act, input int exp);
        exp_checks++;
        if (act != exp) begin
            exp_fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    always begin
        @(posedge clk);
        if (!rst_n) begin
            ms = 0; mcyc = 0; mbit = 0; fl_m = 1'b0;
            hb = '{1'b0, 1'b0, 1'b0};
            hf = '{1'b0, 1'b0};
        end else begin
            automatic logic go = port_en && (clk_div_cfg[0] || clk_div_cfg[4]);
            automatic int fr = frm_of(clk_div_cfg[14:12]);
            automatic int bp = bpf_of(clk_div_cfg[10:8]);
            automatic bit ok = (fr != 0) && (bp != 0) && (fr / bp >= 2);
            automatic logic bc = hb[1] ^ clk_pol_cfg[0];
            automatic logic bpv = hb[0] ^ clk_pol_cfg[0];
            automatic logic fc = hf[1] ^ clk_pol_cfg[4];
            case (ms)
                0: if (go) begin
                    if (ok) begin
                        ms = 1; mdiv = fr / bp; mbpf = bp; mcyc = 0; mbit = 0;
                    end else ms = 3;
                end
                1, 2: begin
                    automatic bit fend = (mcyc == mdiv-1) && (mbit == mbpf-1);
                    if (mcyc == mdiv-1) begin
                        mcyc = 0;
                        mbit = (mbit == mbpf-1) ? 0 : mbit + 1;
                    end else mcyc++;
                    if (!go && fend) begin ms = 0; mcyc = 0; mbit = 0; end
                    else if (!go) ms = 2;
                    else ms = 1;
                end
                default: if (!go) ms = 0;
            endcase
            if (bpv && !bc) fl_m = fc;
            hb.push_back(ext_bclk_i); void'(hb.pop_front());
            hf.push_back(ext_fclk_i); void'(hf.pop_front());
        end
        #(CLK_PERIOD/4);
        if (rst_n) begin
            automatic bit run = (ms == 1) || (ms == 2);
            automatic logic e_b = (run && (mcyc >= mdiv/2)) ^ clk_pol_cfg[8];
            automatic logic e_f = (run && (mbit >= mbpf/2)) ^ clk_pol_cfg[12];
            automatic logic m_bs = run && (mcyc == 0);
            automatic logic m_fs = m_bs && (mbit == 0);
            automatic logic s_bc = hb[1] ^ clk_pol_cfg[0];
            automatic logic s_bp = hb[0] ^ clk_pol_cfg[0];
            automatic logic s_fc = hf[1] ^ clk_pol_cfg[4];
            automatic logic s_bs = port_en && s_bp && !s_bc;
            automatic logic s_fs = s_bs && !s_fc && fl_m;
            cmp("R4", "bclk_o", bclk_o, e_b);
            cmp("R5", "fclk_o", fclk_o, e_f);
            cmp("R12", "clk_oe", clk_oe, clk_div_cfg[0] || clk_div_cfg[4]);
            cmp("R3", "cfg_err", cfg_err, ms == 3);
            cmp("R6", "tx_bit_stb", tx_bit_stb, clk_div_cfg[0] ? m_bs : s_bs);
            cmp("R6", "tx_frame_stb", tx_frame_stb, clk_div_cfg[0] ? m_fs : s_fs);
            cmp("R10", "rx_bit_stb", rx_bit_stb, clk_div_cfg[4] ? m_bs : s_bs);
            cmp("R10", "rx_frame_stb", rx_frame_stb, clk_div_cfg[4] ? m_fs : s_fs);
            if ((clk_div_cfg[0] && tx_frame_stb) || (clk_div_cfg[4] && rx_frame_stb)) begin
                last_len = frm_len; frm_len = 1;
            end else frm_len++;
            if (!clk_div_cfg[0] && tx_bit_stb) slv_bits++;
            if (!clk_div_cfg[0] && tx_frame_stb) slv_frames++;
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_cfg(input int fc, input int bc, input bit mo, input bit mi);
        clk_div_cfg = 16'h0;
        clk_div_cfg[14:12] = 3'(fc);
        clk_div_cfg[10:8]  = 3'(bc);
        clk_div_cfg[0] = mo;
        clk_div_cfg[4] = mi;
    endtask

    task automatic slave_drive(input int h, input int bits, input int frames);
        for (int f = 0; f < frames; f++) begin
            for (int b = 0; b < bits; b++) begin
                ext_fclk_i = (b >= bits/2) ^ clk_pol_cfg[4];
                ext_bclk_i = 1'b0 ^ clk_pol_cfg[0];
                cyc(h);
                ext_bclk_i = 1'b1 ^ clk_pol_cfg[0];
                cyc(h);
            end
        end
    endtask

    task automatic scenarios;
        int b0, f0;
        cyc(4);
        rst_n = 1'b1;
        cyc(1);
        // R13 reset state
        chk("R13", "bclk_o", bclk_o, 0);
        chk("R13", "fclk_o", fclk_o, 0);
        chk("R13", "strobes", tx_bit_stb | tx_frame_stb | rx_bit_stb | rx_frame_stb, 0);
        chk("R13", "cfg_err", cfg_err, 0);

        // R1: 256 per frame, 32 bits, divisor 8
        set_cfg(1, 0, 1, 0); port_en = 1'b1;
        cyc(256*3 + 20);
        chk("R1", "frame length code1", last_len, 256);
        port_en = 1'b0; cyc(300);
        chk("R8", "bclk idle after stop", bclk_o, 0);

        // R2: 512 per frame, 16 bits (code 7), receive master
        set_cfg(0, 7, 0, 1); port_en = 1'b1;
        cyc(512*2 + 20);
        chk("R2", "frame length bpf16", last_len, 512);
        port_en = 1'b0; cyc(600);

        // R9: divisor 2 with master inversions
        clk_pol_cfg = 16'h1100;
        set_cfg(3, 0, 1, 0); port_en = 1'b1;
        cyc(64*4 + 10);
        chk("R1", "frame length code3", last_len, 64);
        port_en = 1'b0; cyc(80);
        chk("R9", "inverted idle bclk", bclk_o, 1);
        chk("R9", "inverted idle fclk", fclk_o, 1);
        clk_pol_cfg = 16'h0;

        // R3: illegal settings
        set_cfg(4, 0, 1, 0); port_en = 1'b1; cyc(3);
        chk("R3", "divisor one", cfg_err, 1);
        chk("R3", "clock idle in fault", bclk_o, 0);
        port_en = 1'b0; cyc(2);
        chk("R3", "fault cleared", cfg_err, 0);
        set_cfg(0, 5, 1, 0); port_en = 1'b1; cyc(3);
        chk("R2", "bpf code 5 illegal", cfg_err, 1);
        port_en = 1'b0; cyc(2);
        set_cfg(6, 0, 1, 0); port_en = 1'b1; cyc(3);
        chk("R1", "frame code 6 illegal", cfg_err, 1);
        port_en = 1'b0; cyc(2);
        set_cfg(0, 4, 1, 0); port_en = 1'b1; cyc(3);
        chk("R3", "512 over 512", cfg_err, 1);
        port_en = 1'b0; cyc(2);
        set_cfg(2, 1, 1, 0); port_en = 1'b1; cyc(3);
        chk("R3", "128 over 64 legal", cfg_err, 0);
        port_en = 1'b0; cyc(140);

        // R7: no start without a master bit; ratios latched
        set_cfg(1, 0, 0, 0); port_en = 1'b1; cyc(20);
        chk("R7", "no master clock", bclk_o | tx_frame_stb, 0);
        port_en = 1'b0; cyc(4);
        set_cfg(1, 0, 1, 0); port_en = 1'b1; cyc(30);
        set_cfg(0, 0, 1, 0);
        cyc(256*3);
        chk("R7", "ratio change ignored", last_len, 256);

        // R8: drop and restore inside a frame
        port_en = 1'b0; cyc(20);
        port_en = 1'b1; cyc(256*2);
        chk("R8", "resumed frame length", last_len, 256);
        port_en = 1'b0; cyc(600);
        chk("R8", "idle at end", bclk_o | fclk_o, 0);

        // R10/R11: slave mode with inverted pins
        set_cfg(0, 0, 0, 0);
        clk_pol_cfg = 16'h0011;
        ext_bclk_i = 1'b1; ext_fclk_i = 1'b1;
        b0 = slv_bits;
        cyc(6);
        chk("R10", "no strobe while disabled", slv_bits - b0, 0);
        port_en = 1'b1; cyc(1);
        b0 = slv_bits; f0 = slv_frames;
        slave_drive(3, 8, 4);
        cyc(4);
        chk("R10", "slave bit strobes", slv_bits - b0, 31);
        chk("R11", "slave frame strobes", slv_frames - f0, 3);

        // R12: transmit master, receive slave
        set_cfg(3, 0, 1, 0);
        slave_drive(4, 8, 2);
        chk("R12", "clk_oe mixed", clk_oe, 1);
        port_en = 1'b0; cyc(80);
        clk_pol_cfg = 16'h0;
    endtask

    initial begin
        bit timed_out = 1'b0;
        fork
            scenarios();
            begin
                repeat (WDOG_CYC) @(posedge clk);
                timed_out = 1'b1;
            end
        join_any
        disable fork;
        if (timed_out) chk("R13", "watchdog expired", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures",
                 mdl_checks + exp_checks, mdl_fails + exp_fails);
        $finish;
    end

endmodule